// File: doc/BRIEF.md
# Machine-Mode Control Register and Trap Unit

This block holds the machine-level control and status registers of a small 32-bit hart that runs only at the highest privilege level, and it sequences trap entry and trap return. The pipeline reaches the registers through a simple port: a 12-bit register number, read and write strobes, write data and the current privilege level. The block answers on the next cycle with registered read data and an error flag.

When the pipeline raises a trap, it supplies the cause code, an interrupt flag, the PC of the affected instruction and its instruction word. The block records the return address, the cause and the trap value, and it updates the interrupt-enable stack. One cycle later it presents the handler address on a registered redirect output. A return strobe pops the interrupt-enable stack and redirects to the saved return address.

Each register applies its own masking. Some registers are masked when written and some when read. A few registers are fixed identification constants. The whole performance-counter range reads as zero. An optional group of debug registers can be included through a parameter.

Top module: `mtrap_csr_unit`

## Requirements
- R1: An access is refused (csr_err = 1 and csr_rdata = 0 on the next cycle, no register changes) when register-number bits [9:8] exceed cur_priv, or when the number is not implemented. The implemented numbers are 0x300, 0x301, 0x304, 0x305, 0x340 to 0x344, 0xF11 to 0xF14, 0x7B0 to 0x7B3 and the counter ranges of R3.
- R2: The identification registers are fixed and ignore writes without error. 0x301 reads MISA_VAL (default 0x40001104), 0xF11 reads 0x669, 0xF12 reads 0, 0xF13 reads 1 and 0xF14 reads HART_ID.
- R3: Register numbers 0xB03–0xB1F, 0xB83–0xB9F, 0x323–0x33F, 0xC03–0xC1F and 0xC83–0xC9F read as zero, accept writes without error and ignore them.
- R4: A write to 0x342 keeps only bit 31 and the low CAUSE_W bits (0x8000000F by default).
- R5: A read of 0x305 returns the stored value with bit 1 cleared. Bit 0 of the stored value selects vectored mode.
- R6: A write to 0x344 changes only bits 3 and 11, and bit 7 stays 0. A write to 0x304 changes only bits 3, 7 and 11.
- R7: A write to 0x341 is ANDed with PC_MASK (0xFFFFFFFE by default).
- R8: When DEBUG_EN is set, a write to 0x7B0 is ANDed with 0x000089C4. The registers 0x7B1 to 0x7B3 store writes as given.
- R9: On a trap, 0x341 takes trap_pc AND PC_MASK, and 0x342 takes {trap_irq, cause} in bit 31 and the low bits. An exception with cause 8, 9 or 11 is recorded as cause 11.
- R10: On trap entry, 0x343 receives one of three values. For exception cause 2 it receives the whole instruction when its low two bits are 11, and otherwise the instruction's low 16 bits. For exception cause 3 it receives trap_pc. In all other cases it receives 0.
- R11: Register 0x300 has MIE at bit 3 and MPIE at bit 7, and its bits 12:11 always read 11. Trap entry copies MIE into MPIE and clears MIE. The handler address is the trap vector base (low 2 bits cleared). For an interrupt in vectored mode, it is that base plus 4 times the cause.
- R12: The return strobe loads MIE from MPIE, sets MPIE, and redirects to the saved return address.
- R13: redirect_vld pulses for one cycle, on the cycle after a trap or return strobe. A trap takes priority over a return, and either one drops a register write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register number |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| cur_priv | input | 2 | Current privilege level |
| csr_rdata | output | 32 | Registered read data |
| csr_err | output | 1 | Registered access error |
| trap_req | input | 1 | Trap entry strobe |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_cause | input | CAUSE_W | Cause code |
| trap_pc | input | 32 | PC of affected instruction |
| trap_instr | input | 32 | Instruction word |
| mret_req | input | 1 | Trap return strobe |
| redirect_vld | output | 1 | Redirect pulse |
| redirect_pc | output | 32 | Handler or return address |

## Verification
The checker watches several rules on every cycle. It checks the privilege refusal, that the error flag stays quiet when there is no access, and that the redirect pulse follows the trap and return strobes. It also checks the interrupt-enable stack movement on entry and return, the return address, and the alignment of the saved return address. The masking of individual registers, the cause rewriting and trap-value selection, the vector address arithmetic and the dropped write under a trap are data-dependent. Only the bench's directed scenarios, which read back the registers, can show them.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_ISA     = 12'h301;
  localparam logic [11:0] A_IE      = 12'h304;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;
  localparam logic [11:0] A_IP      = 12'h344;
  localparam logic [11:0] A_VENDOR  = 12'hF11;
  localparam logic [11:0] A_ARCH    = 12'hF12;
  localparam logic [11:0] A_IMPL    = 12'hF13;
  localparam logic [11:0] A_HART    = 12'hF14;
  localparam logic [11:0] A_DCTL    = 12'h7B0;
  localparam logic [11:0] A_DPC     = 12'h7B1;
  localparam logic [11:0] A_DSCR0   = 12'h7B2;
  localparam logic [11:0] A_DSCR1   = 12'h7B3;

  localparam logic [31:0] DCTL_KEEP = 32'h0000_89C4;
  localparam int          TIMER_BIT = 7;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_STATUS, SEL_ISA, SEL_IE, SEL_TVEC, SEL_SCRATCH,
    SEL_EPC, SEL_CAUSE, SEL_TVAL, SEL_IP, SEL_VENDOR, SEL_ARCH,
    SEL_IMPL, SEL_HART, SEL_ZERO, SEL_DCTL, SEL_DPC, SEL_DSCR0, SEL_DSCR1
  } csr_sel_e;

  function automatic logic in_counter_range(input logic [11:0] a);
    logic hi_ok;
    hi_ok = (a[11:5] == 7'h58) || (a[11:5] == 7'h5C) || (a[11:5] == 7'h19) ||
            (a[11:5] == 7'h60) || (a[11:5] == 7'h64);
    return hi_ok && (a[4:0] >= 5'd3);
  endfunction
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
#(
  parameter bit DEBUG_EN = 1'b1
) (
  input  logic [11:0] addr,
  input  logic [1:0]  priv,
  input  logic        access,
  output csr_sel_e    sel,
  output logic        err
);
  always_comb begin
    sel = SEL_NONE;
    case (addr)
      A_STATUS:  sel = SEL_STATUS;
      A_ISA:     sel = SEL_ISA;
      A_IE:      sel = SEL_IE;
      A_TVEC:    sel = SEL_TVEC;
      A_SCRATCH: sel = SEL_SCRATCH;
      A_EPC:     sel = SEL_EPC;
      A_CAUSE:   sel = SEL_CAUSE;
      A_TVAL:    sel = SEL_TVAL;
      A_IP:      sel = SEL_IP;
      A_VENDOR:  sel = SEL_VENDOR;
      A_ARCH:    sel = SEL_ARCH;
      A_IMPL:    sel = SEL_IMPL;
      A_HART:    sel = SEL_HART;
      A_DCTL:    sel = DEBUG_EN ? SEL_DCTL  : SEL_NONE;
      A_DPC:     sel = DEBUG_EN ? SEL_DPC   : SEL_NONE;
      A_DSCR0:   sel = DEBUG_EN ? SEL_DSCR0 : SEL_NONE;
      A_DSCR1:   sel = DEBUG_EN ? SEL_DSCR1 : SEL_NONE;
      default:   sel = in_counter_range(addr) ? SEL_ZERO : SEL_NONE;
    endcase
  end

  // refused when the level encoded in the number is above the caller's
  assign err = access && ((addr[9:8] > priv) || (sel == SEL_NONE));
endmodule

// File: rtl/mcsr_trap_calc.sv
module mcsr_trap_calc #(
  parameter int          CAUSE_W = 4,
  parameter logic [31:0] PC_MASK = 32'hFFFF_FFFE
) (
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [31:0]        pc,
  input  logic [31:0]        instr,
  input  logic [31:0]        tvec,
  output logic [31:0]        cause_word,
  output logic [31:0]        tval,
  output logic [31:0]        epc,
  output logic [31:0]        target
);
  localparam logic [CAUSE_W-1:0] C_ILLEGAL = CAUSE_W'(2);
  localparam logic [CAUSE_W-1:0] C_BREAK   = CAUSE_W'(3);
  localparam logic [CAUSE_W-1:0] C_ECALL_M = CAUSE_W'(11);

  logic [CAUSE_W-1:0] cause_eff;
  logic [31:0]        base;

  always_comb begin
    cause_eff = cause;
    if (!is_irq && (cause == CAUSE_W'(8) || cause == CAUSE_W'(9) || cause == C_ECALL_M))
      cause_eff = C_ECALL_M;
  end

  assign cause_word = {is_irq, {(31-CAUSE_W){1'b0}}, cause_eff};
  assign epc        = pc & PC_MASK;

  always_comb begin
    tval = '0;
    if (!is_irq && cause_eff == C_ILLEGAL)
      tval = (instr[1:0] == 2'b11) ? instr : {16'h0000, instr[15:0]};
    else if (!is_irq && cause_eff == C_BREAK)
      tval = pc;
  end

  assign base   = tvec & ~32'h3;
  assign target = (is_irq && tvec[0]) ? base + ({{(32-CAUSE_W){1'b0}}, cause_eff} << 2) : base;
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
  import mcsr_pkg::*;
#(
  parameter int          CAUSE_W  = 4,
  parameter logic [31:0] PC_MASK  = 32'hFFFF_FFFE,
  parameter logic [31:0] IRQ_MASK = 32'h0000_0888,
  parameter logic [31:0] MISA_VAL = 32'h4000_1104,
  parameter logic [31:0] HART_ID  = 32'h0,
  parameter bit          DEBUG_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [11:0]        csr_addr,
  input  logic               csr_rd,
  input  logic               csr_wr,
  input  logic [31:0]        csr_wdata,
  input  logic [1:0]         cur_priv,
  output logic [31:0]        csr_rdata,
  output logic               csr_err,
  input  logic               trap_req,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [31:0]        trap_pc,
  input  logic [31:0]        trap_instr,
  input  logic               mret_req,
  output logic               redirect_vld,
  output logic [31:0]        redirect_pc
);
  localparam logic [31:0] CAUSE_KEEP = 32'h8000_0000 | ((32'd1 << CAUSE_W) - 32'd1);
  localparam logic [31:0] IP_WMASK   = IRQ_MASK & ~(32'd1 << TIMER_BIT);

  csr_sel_e    sel;
  logic        dec_err, wr_go;
  logic        st_mie, st_mpie;
  logic [31:0] irq_en_q, irq_pend_q, tvec_q, scratch_q, epc_q, cause_q, tval_q;
  logic [31:0] tc_cause, tc_tval, tc_epc, tc_target;
  logic [31:0] dbg_rdata, rd_val;

  mcsr_decode #(.DEBUG_EN(DEBUG_EN)) u_dec (
    .addr(csr_addr), .priv(cur_priv), .access(csr_rd | csr_wr),
    .sel(sel), .err(dec_err)
  );

  mcsr_trap_calc #(.CAUSE_W(CAUSE_W), .PC_MASK(PC_MASK)) u_trap (
    .is_irq(trap_irq), .cause(trap_cause), .pc(trap_pc), .instr(trap_instr),
    .tvec(tvec_q), .cause_word(tc_cause), .tval(tc_tval), .epc(tc_epc),
    .target(tc_target)
  );

  // trap and return own the cycle; a concurrent register write is dropped
  assign wr_go = csr_wr && !dec_err && !trap_req && !mret_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_mie     <= 1'b0;
      st_mpie    <= 1'b0;
      irq_en_q   <= '0;
      irq_pend_q <= '0;
      tvec_q     <= '0;
      scratch_q  <= '0;
      epc_q      <= '0;
      cause_q    <= '0;
      tval_q     <= '0;
    end else if (trap_req) begin
      st_mpie <= st_mie;
      st_mie  <= 1'b0;
      epc_q   <= tc_epc;
      cause_q <= tc_cause;
      tval_q  <= tc_tval;
    end else if (mret_req) begin
      st_mie  <= st_mpie;
      st_mpie <= 1'b1;
    end else if (wr_go) begin
      case (sel)
        SEL_STATUS: begin
          st_mie  <= csr_wdata[3];
          st_mpie <= csr_wdata[7];
        end
        SEL_IE:      irq_en_q   <= (irq_en_q & ~IRQ_MASK) | (csr_wdata & IRQ_MASK);
        SEL_IP:      irq_pend_q <= (irq_pend_q & ~IP_WMASK) | (csr_wdata & IP_WMASK);
        SEL_TVEC:    tvec_q     <= csr_wdata;
        SEL_SCRATCH: scratch_q  <= csr_wdata;
        SEL_EPC:     epc_q      <= csr_wdata & PC_MASK;
        SEL_CAUSE:   cause_q    <= csr_wdata & CAUSE_KEEP;
        SEL_TVAL:    tval_q     <= csr_wdata;
        default: ;
      endcase
    end
  end

  generate
    if (DEBUG_EN) begin : g_dbg
      logic [31:0] dctl_q, dpc_q, dscr0_q, dscr1_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dctl_q  <= '0;
          dpc_q   <= '0;
          dscr0_q <= '0;
          dscr1_q <= '0;
        end else if (wr_go) begin
          case (sel)
            SEL_DCTL:  dctl_q  <= csr_wdata & DCTL_KEEP;
            SEL_DPC:   dpc_q   <= csr_wdata;
            SEL_DSCR0: dscr0_q <= csr_wdata;
            SEL_DSCR1: dscr1_q <= csr_wdata;
            default: ;
          endcase
        end
      end
      always_comb begin
        case (sel)
          SEL_DCTL:  dbg_rdata = dctl_q;
          SEL_DPC:   dbg_rdata = dpc_q;
          SEL_DSCR0: dbg_rdata = dscr0_q;
          SEL_DSCR1: dbg_rdata = dscr1_q;
          default:   dbg_rdata = '0;
        endcase
      end
    end else begin : g_nodbg
      assign dbg_rdata = '0;
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_STATUS:  rd_val = {19'b0, 2'b11, 3'b0, st_mpie, 3'b0, st_mie, 3'b0};
      SEL_ISA:     rd_val = MISA_VAL;
      SEL_IE:      rd_val = irq_en_q;
      SEL_IP:      rd_val = irq_pend_q;
      SEL_TVEC:    rd_val = tvec_q & ~32'h2;
      SEL_SCRATCH: rd_val = scratch_q;
      SEL_EPC:     rd_val = epc_q;
      SEL_CAUSE:   rd_val = cause_q;
      SEL_TVAL:    rd_val = tval_q;
      SEL_VENDOR:  rd_val = 32'h0000_0669;
      SEL_ARCH:    rd_val = 32'h0;
      SEL_IMPL:    rd_val = 32'h1;
      SEL_HART:    rd_val = HART_ID;
      default:     rd_val = dbg_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata    <= '0;
      csr_err      <= 1'b0;
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
    end else begin
      csr_rdata    <= (csr_rd && !dec_err) ? rd_val : 32'h0;
      csr_err      <= dec_err;
      redirect_vld <= trap_req || mret_req;
      if (trap_req)      redirect_pc <= tc_target;
      else if (mret_req) redirect_pc <= epc_q;
    end
  end
endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk #(
  parameter logic [31:0] PC_MASK = 32'hFFFF_FFFE
) (
  input logic        clk,
  input logic        rst,
  input logic [11:0] csr_addr,
  input logic        csr_rd,
  input logic        csr_wr,
  input logic [1:0]  cur_priv,
  input logic        csr_err,
  input logic        trap_req,
  input logic        mret_req,
  input logic        redirect_vld,
  input logic [31:0] redirect_pc,
  input logic        st_mie,
  input logic        st_mpie,
  input logic [31:0] epc_q
);
  p_priv_err_r1: assert property (@(posedge clk) disable iff (rst)
    ((csr_rd || csr_wr) && (csr_addr[9:8] > cur_priv)) |=> csr_err);

  p_quiet_err_r13: assert property (@(posedge clk) disable iff (rst)
    !(csr_rd || csr_wr) |=> !csr_err);

  p_redirect_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    (trap_req || mret_req) |=> redirect_vld);

  p_redirect_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !(trap_req || mret_req) |=> !redirect_vld);

  p_entry_stack_r11: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> (!st_mie && (st_mpie == $past(st_mie))));

  p_return_r12: assert property (@(posedge clk) disable iff (rst)
    (mret_req && !trap_req) |=>
      (st_mpie && (st_mie == $past(st_mpie)) && (redirect_pc == $past(epc_q))));

  p_epc_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    (epc_q & ~PC_MASK) == 32'h0);
endmodule

bind mtrap_csr_unit mcsr_unit_chk #(.PC_MASK(PC_MASK)) u_chk (
  .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
  .cur_priv(cur_priv), .csr_err(csr_err), .trap_req(trap_req), .mret_req(mret_req),
  .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .st_mie(st_mie),
  .st_mpie(st_mpie), .epc_q(epc_q)
);

// File: tb/tb_mtrap_csr_unit.sv
`timescale 1ns/1ps
module tb_mtrap_csr_unit;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [11:0]   csr_addr;
  logic          csr_rd, csr_wr;
  logic [31:0]   csr_wdata;
  logic [1:0]    cur_priv;
  logic [31:0]   csr_rdata;
  logic          csr_err;
  logic          trap_req, trap_irq;
  logic [CW-1:0] trap_cause;
  logic [31:0]   trap_pc, trap_instr;
  logic          mret_req;
  logic          redirect_vld;
  logic [31:0]   redirect_pc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mtrap_csr_unit #(.CAUSE_W(CW)) dut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .cur_priv(cur_priv), .csr_rdata(csr_rdata),
    .csr_err(csr_err), .trap_req(trap_req), .trap_irq(trap_irq),
    .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_instr(trap_instr),
    .mret_req(mret_req), .redirect_vld(redirect_vld), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    csr_rd = 0; csr_wr = 0; trap_req = 0; mret_req = 0; trap_irq = 0;
    csr_addr = '0; csr_wdata = '0; trap_cause = '0; trap_pc = '0; trap_instr = '0;
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] p,
                       output logic err);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; cur_priv = p; csr_wr = 1;
    @(negedge clk);
    err = csr_err;
    idle();
  endtask

  task automatic do_rd(input logic [11:0] a, input logic [1:0] p,
                       output logic [31:0] d, output logic err);
    @(negedge clk);
    csr_addr = a; cur_priv = p; csr_rd = 1;
    @(negedge clk);
    d = csr_rdata; err = csr_err;
    idle();
  endtask

  task automatic do_trap(input logic irq, input logic [CW-1:0] c, input logic [31:0] pc,
                         input logic [31:0] ins, output logic [31:0] tgt);
    @(negedge clk);
    trap_req = 1; trap_irq = irq; trap_cause = c; trap_pc = pc; trap_instr = ins;
    @(negedge clk);
    tgt = redirect_pc;
    chk("R13 redirect pulse", {31'b0, redirect_vld}, 32'h1);
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    do_rd(12'h300, 2'd3, d, e); chk("R11 reset status", d, 32'h0000_1800);
    chk("R13 no redirect", {31'b0, redirect_vld}, 32'h0);
    do_rd(12'hF11, 2'd3, d, e); chk("R2 vendor", d, 32'h669);
  endtask

  task automatic t_priv();
    logic [31:0] d; logic e;
    do_rd(12'h300, 2'd0, d, e); chk("R1 priv err", {31'b0, e}, 32'h1); chk("R1 zero data", d, 0);
    do_wr(12'h340, 32'hDEAD_BEEF, 2'd1, e); chk("R1 priv wr err", {31'b0, e}, 32'h1);
    do_rd(12'h340, 2'd3, d, e); chk("R1 no change", d, 32'h0); chk("R1 ok access", {31'b0, e}, 0);
    do_rd(12'h7C0, 2'd3, d, e); chk("R1 unimplemented", {31'b0, e}, 32'h1);
  endtask

  task automatic t_ident();
    logic [31:0] d; logic e;
    do_wr(12'h301, 32'hFFFF_FFFF, 2'd3, e); chk("R2 write accepted", {31'b0, e}, 0);
    do_rd(12'h301, 2'd3, d, e); chk("R2 isa", d, 32'h4000_1104);
    do_wr(12'hF11, 32'h0, 2'd3, e);
    do_rd(12'hF11, 2'd3, d, e); chk("R2 vendor kept", d, 32'h669);
    do_rd(12'hF13, 2'd3, d, e); chk("R2 impl", d, 32'h1);
    do_rd(12'hF12, 2'd3, d, e); chk("R2 arch", d, 32'h0);
  endtask

  task automatic t_counters();
    logic [31:0] d; logic e;
    do_wr(12'hB05, 32'h1234, 2'd3, e); chk("R3 write no err", {31'b0, e}, 0);
    do_rd(12'hB05, 2'd3, d, e); chk("R3 counter zero", d, 0);
    do_rd(12'hB9F, 2'd3, d, e); chk("R3 high zero", d, 0); chk("R3 high ok", {31'b0, e}, 0);
    do_rd(12'h33F, 2'd3, d, e); chk("R3 event zero", d, 0);
    do_rd(12'hC03, 2'd0, d, e); chk("R3 user view ok", {31'b0, e}, 0);
  endtask

  task automatic t_masks();
    logic [31:0] d; logic e;
    do_wr(12'h342, 32'hFFFF_FFFF, 2'd3, e);
    do_rd(12'h342, 2'd3, d, e); chk("R4 cause mask", d, 32'h8000_000F);
    do_wr(12'h305, 32'h0000_1003, 2'd3, e);
    do_rd(12'h305, 2'd3, d, e); chk("R5 tvec bit1", d, 32'h0000_1001);
    do_wr(12'h344, 32'hFFFF_FFFF, 2'd3, e);
    do_rd(12'h344, 2'd3, d, e); chk("R6 ip mask", d, 32'h0000_0808);
    do_wr(12'h304, 32'hFFFF_FFFF, 2'd3, e);
    do_rd(12'h304, 2'd3, d, e); chk("R6 ie mask", d, 32'h0000_0888);
    do_wr(12'h341, 32'h0000_1235, 2'd3, e);
    do_rd(12'h341, 2'd3, d, e); chk("R7 epc align", d, 32'h0000_1234);
    do_wr(12'h7B0, 32'hFFFF_FFFF, 2'd3, e);
    do_rd(12'h7B0, 2'd3, d, e); chk("R8 debug ctl", d, 32'h0000_89C4);
    do_wr(12'h7B2, 32'hA5A5_0001, 2'd3, e);
    do_rd(12'h7B2, 2'd3, d, e); chk("R8 debug scratch", d, 32'hA5A5_0001);
  endtask

  task automatic t_exceptions();
    logic [31:0] d, t; logic e;
    do_wr(12'h305, 32'h0000_2000, 2'd3, e);
    do_trap(1'b0, 4'd8, 32'h0000_0400, 32'h0, t); chk("R11 direct target", t, 32'h2000);
    do_rd(12'h342, 2'd3, d, e); chk("R9 ecall cause", d, 32'hB);
    do_rd(12'h341, 2'd3, d, e); chk("R9 epc", d, 32'h400);
    do_trap(1'b0, 4'd5, 32'h0000_0503, 32'h0, t);
    do_rd(12'h341, 2'd3, d, e); chk("R9 epc masked", d, 32'h502);
    do_rd(12'h343, 2'd3, d, e); chk("R10 other tval", d, 0);
    do_trap(1'b0, 4'd2, 32'h0000_0600, 32'h1234_5673, t);
    do_rd(12'h343, 2'd3, d, e); chk("R10 illegal full", d, 32'h1234_5673);
    do_trap(1'b0, 4'd2, 32'h0000_0600, 32'hABCD_1231, t);
    do_rd(12'h343, 2'd3, d, e); chk("R10 illegal short", d, 32'h0000_1231);
    do_trap(1'b0, 4'd3, 32'h0000_0880, 32'h0, t);
    do_rd(12'h343, 2'd3, d, e); chk("R10 break pc", d, 32'h880);
  endtask

  task automatic t_interrupt();
    logic [31:0] d, t; logic e;
    do_wr(12'h300, 32'hFFFF_FFFF, 2'd3, e);
    do_rd(12'h300, 2'd3, d, e); chk("R11 status write", d, 32'h0000_1888);
    do_wr(12'h300, 32'h0000_0008, 2'd3, e);
    do_wr(12'h305, 32'h0000_2001, 2'd3, e);
    do_trap(1'b1, 4'd7, 32'h0000_0704, 32'h0, t); chk("R11 vectored target", t, 32'h201C);
    do_rd(12'h300, 2'd3, d, e); chk("R11 stack push", d, 32'h0000_1880);
    do_rd(12'h342, 2'd3, d, e); chk("R9 irq cause", d, 32'h8000_0007);
    do_trap(1'b0, 4'd4, 32'h0000_0708, 32'h0, t); chk("R11 exc ignores vector", t, 32'h2000);
  endtask

  task automatic t_return();
    logic [31:0] d; logic e;
    do_wr(12'h300, 32'h0000_0080, 2'd3, e);
    do_wr(12'h341, 32'h0000_3000, 2'd3, e);
    @(negedge clk); mret_req = 1;
    @(negedge clk);
    chk("R12 return pc", redirect_pc, 32'h3000);
    chk("R13 return pulse", {31'b0, redirect_vld}, 1);
    idle();
    @(negedge clk); chk("R13 pulse ends", {31'b0, redirect_vld}, 0);
    do_rd(12'h300, 2'd3, d, e); chk("R12 stack pop", d, 32'h0000_1888);
  endtask

  task automatic t_priority();
    logic [31:0] d; logic e;
    do_wr(12'h340, 32'h1111_1111, 2'd3, e);
    do_wr(12'h305, 32'h0000_4000, 2'd3, e);
    @(negedge clk);
    csr_wr = 1; csr_addr = 12'h340; csr_wdata = 32'h2222_2222; cur_priv = 2'd3;
    trap_req = 1; trap_cause = 4'd1; trap_pc = 32'h900; mret_req = 1;
    @(negedge clk);
    chk("R13 trap beats return", redirect_pc, 32'h4000);
    idle();
    do_rd(12'h340, 2'd3, d, e); chk("R13 write dropped", d, 32'h1111_1111);
    do_rd(12'h341, 2'd3, d, e); chk("R13 trap recorded", d, 32'h900);
  endtask

  initial begin
    idle(); cur_priv = 2'd3; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_priv();
    t_ident();
    t_counters();
    t_masks();
    t_exceptions();
    t_interrupt();
    t_return();
    t_priority();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule